// File: doc/BRIEF.md
# Shadow-Buffered Raster Timing Generator for Parallel RGB Panels

This block produces the timing skeleton for a parallel RGB panel: a pixel-clock enable and a matching pixel-clock output, horizontal and vertical sync pulses, a data-enable strobe, and horizontal and vertical position counters. Pixel data itself is supplied elsewhere. The block qualifies that data with the data-enable strobe and the position counters.

Software sets up the timing through a plain register port. A write strobe carries the address and data, and reads are combinational from a read address. Every porch, pulse and size field holds its count minus one. Timing fields, the divider and the video-enable bit are staged. They are copied into a live set only at the first tick of vertical sync, and only when the hold bit is clear. As a result, a half-written configuration never reaches the panel. The same instant can raise a frame interrupt, which is cleared by writing one to its status bit.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line runs active, front porch, sync, back porch. The phases last (width field+1), (front field+1), (sync field+1) and (back field+1) pixel ticks. Horizontal sync is active during the sync phase. HTIME (address 2) holds sync-1 in [7:0], front-1 in [15:8] and back-1 in [23:16].
- R2: The frame follows the same phase order in lines, using VTIME (address 3, same layout) and height-1. Vertical sync starts on the first tick of a line. The first data-enable tick comes (vsync+vback) lines after vertical sync starts.
- R3: When video is live, data-enable is active for width ticks in each of height lines. SIZE (address 4) holds width-1 in [10:0] and height-1 in [26:16]. When video is not live, data-enable stays inactive.
- R4: CLKDIV (address 1) holds d = divisor-1. A pixel tick occurs once every d+1 source cycles. The pixel-clock output is high for (d>>1)+1 cycles of each period. With d=0 the divider is bypassed and every cycle is a tick.
- R5: CTRL (address 0) bits [4],[5],[6],[7] invert horizontal sync, vertical sync, data-enable and the pixel-clock output. They take effect immediately.
- R6: Writes to CLKDIV, HTIME, VTIME, SIZE and CTRL bit [0] (video on) are staged. They read back at once, but the outputs follow them only from the next vertical-sync start.
- R7: While CTRL bit [1] (hold) is set, the copy at vertical-sync start is skipped. After the bit is cleared, the next vertical-sync start applies all staged values.
- R8: At vertical-sync start, the pending flag (STATUS address 5 bit [0], and the irq output) is set if CTRL bits [2] and [3] are both set. Writing one to STATUS bit [0] clears the flag. Writing zero has no effect. With only one enable set, the flag is not set.
- R9: Clearing the video bit stops data-enable only from the next vertical-sync start. The current frame's remaining active lines still get data-enable.
- R10: After reset all registers read zero, both axes sit at the start of their back porch, the sync and data-enable outputs are inactive, and irq is low.
- R11: On the first data-enable tick of a frame, h_pos and v_pos are both 0. On the last data-enable tick they are width-1 and height-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (staged values) |
| pix_en | output | 1 | Pixel-clock enable, one source cycle per pixel |
| lcd_pclk | output | 1 | Pixel-clock output after optional inversion |
| lcd_hsync | output | 1 | Horizontal sync after optional inversion |
| lcd_vsync | output | 1 | Vertical sync after optional inversion |
| lcd_de | output | 1 | Data-enable after optional inversion |
| h_pos | output | 13 | Pixel ticks since the first active pixel of the line |
| v_pos | output | 13 | Lines since the first active line of the frame |
| irq | output | 1 | Frame interrupt pending |

## Verification
The in-RTL properties rely on one condition: new limits reach the counters only on the edge where vertical sync begins. On that edge the horizontal axis has just wrapped and the vertical axis has just entered sync, so both phase counters are zero and no counter can sit beyond a freshly loaded smaller limit. They also assume the combined porch, pulse and size fields fit the position counters. Stimulus respects both conditions because it writes configuration only through the register port. Random porch, pulse, size and divisor values are drawn from a fixed-seed generator in narrow ranges, so that a full frame stays within a few thousand cycles. Directed cases cover the bypassed divider, inversion, the hold bit, mid-frame writes and interrupt clearing.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   typedef enum logic [1:0] {
      PH_ACT  = 2'd0,
      PH_FP   = 2'd1,
      PH_SYNC = 2'd2,
      PH_BP   = 2'd3
   } lcdt_phase_e;

   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_CLKDIV = 1;
   localparam int unsigned REG_HTIME  = 2;
   localparam int unsigned REG_VTIME  = 3;
   localparam int unsigned REG_SIZE   = 4;
   localparam int unsigned REG_STATUS = 5;

   localparam int unsigned CTL_VIDEO    = 0;
   localparam int unsigned CTL_HOLD     = 1;
   localparam int unsigned CTL_IRQ_EN   = 2;
   localparam int unsigned CTL_FRM_IRQ  = 3;
   localparam int unsigned CTL_INV_HS   = 4;
   localparam int unsigned CTL_INV_VS   = 5;
   localparam int unsigned CTL_INV_DE   = 6;
   localparam int unsigned CTL_INV_PCLK = 7;
   localparam int unsigned CTL_W        = 8;

   localparam int unsigned SIZE_H_LSB = 16;

endpackage

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
   parameter int CNT_W = 11,
   parameter int POS_W = CNT_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic [CNT_W-1:0]         lim_act,
   input  logic [CNT_W-1:0]         lim_fp,
   input  logic [CNT_W-1:0]         lim_sync,
   input  logic [CNT_W-1:0]         lim_bp,
   output lcdt_pkg::lcdt_phase_e    phase,
   output logic                     wrap,
   output logic                     enter_sync,
   output logic [POS_W-1:0]         pos
);
   import lcdt_pkg::*;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_lim;
   logic             at_end;

   always_comb begin
      case (phase)
         PH_ACT:  cur_lim = lim_act;
         PH_FP:   cur_lim = lim_fp;
         PH_SYNC: cur_lim = lim_sync;
         default: cur_lim = lim_bp;
      endcase
   end

   assign at_end     = (cnt == cur_lim);
   assign wrap       = step && at_end && (phase == PH_BP);
   assign enter_sync = step && at_end && (phase == PH_FP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_BP;
         cnt   <= '0;
         pos   <= '0;
      end else if (step) begin
         if (at_end) begin
            cnt   <= '0;
            phase <= lcdt_phase_e'(phase + 2'd1);
         end else begin
            cnt <= cnt + 1'b1;
         end
         pos <= wrap ? '0 : pos + 1'b1;
      end
   end

   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> (phase == lcdt_phase_e'($past(phase) + 2'd1)))
      else $error("phase skipped"); // R1

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cur_lim)
      else $error("phase counter beyond limit"); // R1

endmodule

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
   parameter int DIV_W   = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_m1,
   output logic             tick,
   output logic             clk_hi
);

   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] dc;

         assign tick   = (dc == div_m1);
         assign clk_hi = (dc <= (div_m1 >> 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dc <= '0;
            else if (tick) dc <= '0;
            else           dc <= dc + 1'b1;
         end

         AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            dc <= div_m1)
            else $error("divider count beyond divisor"); // R4

         AST_BYPASS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (div_m1 == '0) |-> (tick && clk_hi))
            else $error("bypass must tick every cycle"); // R4
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{div_m1, clk, rst_n};
         assign tick   = 1'b1;
         assign clk_hi = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int PORCH_W = 8,
   parameter int SIZE_W  = 11,
   parameter int DIV_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                frame_bound,
   output logic [DIV_W-1:0]    div_lv,
   output logic [PORCH_W-1:0]  hsw_lv,
   output logic [PORCH_W-1:0]  hfp_lv,
   output logic [PORCH_W-1:0]  hbp_lv,
   output logic [PORCH_W-1:0]  vsw_lv,
   output logic [PORCH_W-1:0]  vfp_lv,
   output logic [PORCH_W-1:0]  vbp_lv,
   output logic [SIZE_W-1:0]   wid_lv,
   output logic [SIZE_W-1:0]   hgt_lv,
   output logic                video_lv,
   output logic                inv_hs,
   output logic                inv_vs,
   output logic                inv_de,
   output logic                inv_pclk,
   output logic                irq
);
   import lcdt_pkg::*;

   localparam int TIM_W = 3 * PORCH_W;

   logic [CTL_W-1:0]  ctrl_q;
   logic [DIV_W-1:0]  div_st;
   logic [TIM_W-1:0]  htim_st, vtim_st, htim_lv, vtim_lv;
   logic [SIZE_W-1:0] wid_st, hgt_st;
   logic              commit;
   logic              clr_req;
   logic              unused_bits;

   assign unused_bits = ^wr_data;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   assign commit  = frame_bound && !ctrl_q[CTL_HOLD];
   assign clr_req = wr_en && hit(wr_addr, REG_STATUS) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         div_st  <= '0;
         htim_st <= '0;
         vtim_st <= '0;
         wid_st  <= '0;
         hgt_st  <= '0;
      end else if (wr_en) begin
         if (hit(wr_addr, REG_CTRL))   ctrl_q  <= wr_data[CTL_W-1:0];
         if (hit(wr_addr, REG_CLKDIV)) div_st  <= wr_data[DIV_W-1:0];
         if (hit(wr_addr, REG_HTIME))  htim_st <= wr_data[TIM_W-1:0];
         if (hit(wr_addr, REG_VTIME))  vtim_st <= wr_data[TIM_W-1:0];
         if (hit(wr_addr, REG_SIZE)) begin
            wid_st <= wr_data[SIZE_W-1:0];
            hgt_st <= wr_data[SIZE_H_LSB +: SIZE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lv   <= '0;
         htim_lv  <= '0;
         vtim_lv  <= '0;
         wid_lv   <= '0;
         hgt_lv   <= '0;
         video_lv <= 1'b0;
      end else if (commit) begin
         div_lv   <= div_st;
         htim_lv  <= htim_st;
         vtim_lv  <= vtim_st;
         wid_lv   <= wid_st;
         hgt_lv   <= hgt_st;
         video_lv <= ctrl_q[CTL_VIDEO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (frame_bound && ctrl_q[CTL_IRQ_EN] && ctrl_q[CTL_FRM_IRQ])
         irq <= 1'b1;
      else if (clr_req)
         irq <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      if (hit(rd_addr, REG_CTRL))   rd_data[CTL_W-1:0] = ctrl_q;
      if (hit(rd_addr, REG_CLKDIV)) rd_data[DIV_W-1:0] = div_st;
      if (hit(rd_addr, REG_HTIME))  rd_data[TIM_W-1:0] = htim_st;
      if (hit(rd_addr, REG_VTIME))  rd_data[TIM_W-1:0] = vtim_st;
      if (hit(rd_addr, REG_SIZE)) begin
         rd_data[SIZE_W-1:0]             = wid_st;
         rd_data[SIZE_H_LSB +: SIZE_W]   = hgt_st;
      end
      if (hit(rd_addr, REG_STATUS)) rd_data[0] = irq;
   end

   assign hsw_lv   = htim_lv[0 +: PORCH_W];
   assign hfp_lv   = htim_lv[PORCH_W +: PORCH_W];
   assign hbp_lv   = htim_lv[2*PORCH_W +: PORCH_W];
   assign vsw_lv   = vtim_lv[0 +: PORCH_W];
   assign vfp_lv   = vtim_lv[PORCH_W +: PORCH_W];
   assign vbp_lv   = vtim_lv[2*PORCH_W +: PORCH_W];
   assign inv_hs   = ctrl_q[CTL_INV_HS];
   assign inv_vs   = ctrl_q[CTL_INV_VS];
   assign inv_de   = ctrl_q[CTL_INV_DE];
   assign inv_pclk = ctrl_q[CTL_INV_PCLK];

   AST_LIVE_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_bound |=> $stable({div_lv, htim_lv, vtim_lv, wid_lv, hgt_lv, video_lv}))
      else $error("live set changed away from frame boundary"); // R6

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bound && ctrl_q[CTL_HOLD]) |=> $stable({div_lv, htim_lv, vtim_lv, wid_lv, hgt_lv, video_lv}))
      else $error("hold bit did not block update"); // R7

   AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bound && ctrl_q[CTL_IRQ_EN] && ctrl_q[CTL_FRM_IRQ]) |=> irq)
      else $error("frame interrupt missed"); // R8

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_req) |=> irq)
      else $error("pending flag dropped without clear"); // R8

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int PORCH_W = 8,
   parameter int SIZE_W  = 11,
   parameter int DIV_W   = 8,
   parameter bit HAS_DIV = 1'b1,
   localparam int POS_W  = SIZE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              pix_en,
   output logic              lcd_pclk,
   output logic              lcd_hsync,
   output logic              lcd_vsync,
   output logic              lcd_de,
   output logic [POS_W-1:0]  h_pos,
   output logic [POS_W-1:0]  v_pos,
   output logic              irq
);
   import lcdt_pkg::*;

   if (3 * PORCH_W > DATA_W) begin : g_chk_tim
      $error("three timing fields must fit one data word");
   end
   if (SIZE_W > 16 || PORCH_W > SIZE_W || PORCH_W < 1) begin : g_chk_size
      $error("size field must fit 16 bits and cover the porch width");
   end
   if (DIV_W < 1 || DIV_W > DATA_W || ADDR_W < 3) begin : g_chk_div
      $error("divider or address width out of range");
   end

   logic [DIV_W-1:0]   div_lv;
   logic [PORCH_W-1:0] hsw_lv, hfp_lv, hbp_lv, vsw_lv, vfp_lv, vbp_lv;
   logic [SIZE_W-1:0]  wid_lv, hgt_lv;
   logic               video_lv;
   logic               inv_hs, inv_vs, inv_de, inv_pclk;
   logic               frame_bound;
   logic               pclk_hi;
   logic               h_wrap, h_enter_sync, v_wrap;
   lcdt_phase_e        h_phase, v_phase;
   logic               hs_act, vs_act, de_act;
   logic               unused_flags;

   lcdt_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORCH_W(PORCH_W),
      .SIZE_W(SIZE_W), .DIV_W(DIV_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .frame_bound(frame_bound), .div_lv(div_lv),
      .hsw_lv(hsw_lv), .hfp_lv(hfp_lv), .hbp_lv(hbp_lv),
      .vsw_lv(vsw_lv), .vfp_lv(vfp_lv), .vbp_lv(vbp_lv),
      .wid_lv(wid_lv), .hgt_lv(hgt_lv), .video_lv(video_lv),
      .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de),
      .inv_pclk(inv_pclk), .irq(irq)
   );

   lcdt_clkdiv #(.DIV_W(DIV_W), .HAS_DIV(HAS_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .div_m1(div_lv),
      .tick(pix_en), .clk_hi(pclk_hi)
   );

   lcdt_axis #(.CNT_W(SIZE_W), .POS_W(POS_W)) u_haxis (
      .clk(clk), .rst_n(rst_n), .step(pix_en),
      .lim_act(wid_lv), .lim_fp(SIZE_W'(hfp_lv)),
      .lim_sync(SIZE_W'(hsw_lv)), .lim_bp(SIZE_W'(hbp_lv)),
      .phase(h_phase), .wrap(h_wrap), .enter_sync(h_enter_sync), .pos(h_pos)
   );

   lcdt_axis #(.CNT_W(SIZE_W), .POS_W(POS_W)) u_vaxis (
      .clk(clk), .rst_n(rst_n), .step(h_wrap),
      .lim_act(hgt_lv), .lim_fp(SIZE_W'(vfp_lv)),
      .lim_sync(SIZE_W'(vsw_lv)), .lim_bp(SIZE_W'(vbp_lv)),
      .phase(v_phase), .wrap(v_wrap), .enter_sync(frame_bound), .pos(v_pos)
   );

   assign unused_flags = ^{h_enter_sync, v_wrap};

   assign hs_act = (h_phase == PH_SYNC);
   assign vs_act = (v_phase == PH_SYNC);
   assign de_act = (h_phase == PH_ACT) && (v_phase == PH_ACT) && video_lv;

   assign lcd_hsync = hs_act  ^ inv_hs;
   assign lcd_vsync = vs_act  ^ inv_vs;
   assign lcd_de    = de_act  ^ inv_de;
   assign lcd_pclk  = pclk_hi ^ inv_pclk;

   AST_VS_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_act) |-> (h_pos == '0))
      else $error("vertical sync not aligned to line start"); // R2

   AST_DE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      de_act |-> (h_pos <= POS_W'(wid_lv) && v_pos <= POS_W'(hgt_lv)))
      else $error("data enable outside active window"); // R11

   AST_NO_DE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_act || vs_act) |-> !de_act)
      else $error("data enable during sync"); // R3

endmodule

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

   typedef struct {
      int w, h, hfp, hsw, hbp, vfp, vsw, vbp, d;
   } cfg_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        pix_en, lcd_pclk, lcd_hsync, lcd_vsync, lcd_de, irq;
   logic [12:0] h_pos, v_pos;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] ctrl_sh = '0;

   always #10 clk = ~clk;

   lcd_timing_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pix_en(pix_en), .lcd_pclk(lcd_pclk), .lcd_hsync(lcd_hsync),
      .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .h_pos(h_pos),
      .v_pos(v_pos), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ht(input cfg_t c); return c.w + c.hfp + c.hsw + c.hbp; endfunction
   function automatic int vt(input cfg_t c); return c.h + c.vfp + c.vsw + c.vbp; endfunction
   function automatic int hi_per(input cfg_t c); return ((c.d - 1) >> 1) + 1; endfunction

   function automatic bit vs_a(); return lcd_vsync ^ ctrl_sh[5]; endfunction
   function automatic bit hs_a(); return lcd_hsync ^ ctrl_sh[4]; endfunction
   function automatic bit de_a(); return lcd_de    ^ ctrl_sh[6]; endfunction
   function automatic bit pc_a(); return lcd_pclk  ^ ctrl_sh[7]; endfunction

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      ctrl_sh = v;
      wr(0, {24'd0, v});
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = 3'(a);
      #1 d = rd_data;
   endtask

   task automatic load_cfg(input cfg_t c);
      wr(1, 32'(c.d - 1));
      wr(2, {8'd0, 8'(c.hbp - 1), 8'(c.hfp - 1), 8'(c.hsw - 1)});
      wr(3, {8'd0, 8'(c.vbp - 1), 8'(c.vfp - 1), 8'(c.vsw - 1)});
      wr(4, {5'd0, 11'(c.h - 1), 5'd0, 11'(c.w - 1)});
   endtask

   task automatic wait_rise();
      bit pv;
      pv = vs_a();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (vs_a() && !pv) return;
         pv = vs_a();
      end
      chk("R2 vsync rise timeout", 0, 1);
   endtask

   // full=1: whole frame from a vsync rise; full=0: data-enable count to next rise
   task automatic measure(input cfg_t c, input bit vid, input bit full, input string tag);
      int fr = 0, hsc = 0, vsc = 0, dec = 0, pch = 0, first = -1;
      int lh = 0, lv = 0, fh = -1, fv = -1;
      bit pv;
      if (full) wait_rise();
      pv = 1'b1;
      for (int n = 0; n < 60000; n++) begin
         if (n > 0 && vs_a() && !pv) break;
         fr++;
         if (hs_a()) hsc++;
         if (vs_a()) vsc++;
         if (pc_a()) pch++;
         if (de_a()) begin
            if (first < 0) begin first = n; fh = int'(h_pos); fv = int'(v_pos); end
            lh = int'(h_pos); lv = int'(v_pos);
            dec++;
         end
         pv = vs_a();
         @(negedge clk);
      end
      chk({"R3 de ticks ", tag}, dec, vid ? c.w * c.h * c.d : 0);
      if (full) begin
         chk({"R2 frame cycles ", tag}, fr, ht(c) * vt(c) * c.d);
         chk({"R2 vsync cycles ", tag}, vsc, c.vsw * ht(c) * c.d);
         chk({"R1 hsync cycles ", tag}, hsc, c.hsw * vt(c) * c.d);
         chk({"R4 pclk high cycles ", tag}, pch, ht(c) * vt(c) * hi_per(c));
         if (vid) begin
            chk({"R2 first de offset ", tag}, first, (c.vsw + c.vbp) * ht(c) * c.d);
            chk({"R11 first pos ", tag}, fh * 4096 + fv, 0);
            chk({"R11 last pos ", tag}, lh * 4096 + lv, (c.w - 1) * 4096 + (c.h - 1));
         end
      end
   endtask

   task automatic rand_cfg(output cfg_t c);
      c.w   = 1 + int'($urandom % 8);
      c.h   = 1 + int'($urandom % 4);
      c.hfp = 1 + int'($urandom % 4);
      c.hsw = 1 + int'($urandom % 4);
      c.hbp = 1 + int'($urandom % 4);
      c.vfp = 1 + int'($urandom % 3);
      c.vsw = 1 + int'($urandom % 3);
      c.vbp = 1 + int'($urandom % 3);
      c.d   = 1 + int'($urandom % 4);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      cfg_t a, b, c;
      logic [31:0] r;
      void'($urandom(32'd4242));

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk("R10 hsync idle", int'(lcd_hsync), 0);
      chk("R10 vsync idle", int'(lcd_vsync), 0);
      chk("R10 de idle", int'(lcd_de), 0);
      chk("R10 irq idle", int'(irq), 0);
      for (int i = 0; i < 6; i++) begin
         rd(i, r);
         chk("R10 register reads zero", int'(r), 0);
      end

      // R6 readback of staged values
      a = '{w:4, h:3, hfp:2, hsw:3, hbp:2, vfp:1, vsw:2, vbp:1, d:1};
      load_cfg(a);
      rd(2, r); chk("R6 HTIME readback", int'(r), 32'h0001_0102);
      rd(4, r); chk("R6 SIZE readback", int'(r), 32'h0002_0003);
      set_ctrl(8'h01);
      measure(a, 1'b1, 1'b1, "directed bypass");

      b = '{w:6, h:2, hfp:1, hsw:1, hbp:3, vfp:2, vsw:1, vbp:2, d:3};
      load_cfg(b);
      measure(b, 1'b1, 1'b1, "directed div3");

      for (int k = 0; k < 6; k++) begin
         rand_cfg(c);
         load_cfg(c);
         set_ctrl((k == 3) ? 8'h00 : 8'h01);
         measure(c, k != 3, 1'b1, "random");
      end

      // R5 inversion
      rand_cfg(c);
      load_cfg(c);
      set_ctrl(8'hF1);
      measure(c, 1'b1, 1'b1, "R5 inverted");
      set_ctrl(8'h01);
      measure(c, 1'b1, 1'b1, "R5 restored");

      // R7 hold
      load_cfg(a);
      measure(a, 1'b1, 1'b1, "R7 before hold");
      set_ctrl(8'h03);
      load_cfg(b);
      measure(a, 1'b1, 1'b1, "R7 held");
      measure(a, 1'b1, 1'b1, "R7 still held");
      set_ctrl(8'h01);
      measure(b, 1'b1, 1'b1, "R7 released");

      // R6 mid-frame write is deferred
      wait_rise();
      wr(4, {5'd0, 11'd0, 5'd0, 11'd1});
      measure(b, 1'b1, 1'b0, "R6 old size in current frame");
      c = b; c.w = 2; c.h = 1;
      measure(c, 1'b1, 1'b1, "R6 new size next frame");

      // R9 video stop at end of frame
      load_cfg(a);
      measure(a, 1'b1, 1'b1, "R9 running");
      wait_rise();
      set_ctrl(8'h00);
      measure(a, 1'b1, 1'b0, "R9 current frame keeps de");
      measure(a, 1'b0, 1'b1, "R9 stopped");

      // R8 frame interrupt
      set_ctrl(8'h0D);
      wait_rise();
      chk("R8 irq set at vsync start", int'(irq), 1);
      rd(5, r); chk("R8 status reads pending", int'(r), 1);
      wr(5, 32'd0);
      chk("R8 write zero ignored", int'(irq), 1);
      wr(5, 32'd1);
      chk("R8 write one clears", int'(irq), 0);
      set_ctrl(8'h05);
      wait_rise();
      repeat (2) @(negedge clk);
      chk("R8 single enable no irq", int'(irq), 0);
      set_ctrl(8'h09);
      wait_rise();
      repeat (2) @(negedge clk);
      chk("R8 frame enable alone no irq", int'(irq), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule